// File: doc/BRIEF.md
# Floating-Point Status Word Register

This block holds the 16-bit status word of a stack-based floating-point unit. Six sticky bits record the exceptions reported by executed operations. A summary bit flags any recorded exception that the control word does not mask, and a legacy busy bit copies the summary bit. Four condition-code bits are rewritten according to the class of the operation that just finished. The stack-top pointer is not stored here. It arrives on an input and is placed into its field of the word unchanged.

The execution pipeline presents one operation per cycle. It gives an operation class code, the exception bits raised by that operation, and the result details that the class needs: comparison outcome, low quotient bits, whether the reduction is partial, a trigonometric range flag, a round-up flag and a stack fault flag. Control logic can clear the exception bits, initialise the whole word, or overwrite the flags and condition codes from a saved word. The exception-request output follows the summary bit without delay, so it reacts to a change of mask in the same cycle.

Word layout: bits 5..0 are the flags, with invalid at bit 0, then denormal, divide-by-zero, overflow, underflow, and precision at bit 5. Bit 6 reads 0. Bit 7 is the summary. Bit 8 is C0, bit 9 is C1 and bit 10 is C2. Bits 13..11 are the stack top. Bit 14 is C3 and bit 15 is the busy mirror. Operation classes: 0 none, 1 compare, 2 compare-to-integer-flags, 3 partial remainder, 4 trigonometric, 5 arithmetic/store, 6 load/exchange/sign, 7 reserved (behaves as none).

Top module: `fpu_status_word`

## Requirements
- R1: After reset, the flags, summary, busy bit and all four condition bits are 0, and `exc_request` is 0.
- R2: A flag is set by a 1 on its bit of `exc_in` at a clock edge. It then stays set through later operations until a clear, initialise or restore command.
- R3: Bit 7 is 1 exactly when some stored flag has its `exc_mask` bit at 0; a masked exception sets its flag but not bit 7. Bit 15 and `exc_request` always equal bit 7, and a mask change acts without a clock edge.
- R4: `clr_exc` clears bits 5..0 at the next edge, and wins over an exception reported in the same cycle. It does not stop the condition bits from updating for that cycle's operation.
- R5: `init_cmd` clears the flags and all condition bits. `restore_cmd` loads the flags from bits 5..0 and C3/C2/C1/C0 from bits 14/10/9/8 of `restore_word`, ignoring its other bits. Both win over any operation or clear in the same cycle, and initialise wins over restore.
- R6: Compare (class 1) writes `cmp_code` = {C3,C2,C0}, coded 000 greater, 001 less, 100 equal, 111 unordered, and sets C1 to `stack_fault`.
- R7: Compare-to-integer-flags (class 2) sets C1 to `stack_fault` and leaves C3, C2 and C0 unchanged.
- R8: Partial remainder (class 3) sets C2 to `reduce_partial`. When that is 0, C0, C3 and C1 take quotient bits 2, 1 and 0 of `quot_bits`. When it is 1, C0, C3 and C1 keep their values.
- R9: Trigonometric (class 4) sets C2 to `src_out_of_range`. When in range, C1 becomes `round_up` OR `stack_fault`; when out of range, C1 is kept. C0 and C3 are kept.
- R10: Arithmetic/store (class 5) sets C1 to `round_up` OR `stack_fault`. Load/exchange (class 6) sets C1 to `stack_fault`. Both keep C3, C2 and C0.
- R11: Classes 0 and 7 leave all condition bits unchanged, while exceptions reported in that cycle are still recorded.
- R12: Bits 13..11 always equal `top_ptr` without delay, and bit 6 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_in | input | EXC_W | Exceptions raised by this cycle's operation |
| exc_mask | input | EXC_W | Exception masks from the control word, 1 = masked |
| op_class | input | 3 | Class of the operation completing this cycle |
| cmp_code | input | 3 | Compare result as {C3,C2,C0} |
| quot_bits | input | 3 | Low quotient bits {Q2,Q1,Q0} |
| reduce_partial | input | 1 | Remainder reduction not yet complete |
| src_out_of_range | input | 1 | Trigonometric source beyond 2^63 |
| round_up | input | 1 | Result was rounded up in magnitude |
| stack_fault | input | 1 | Stack overflow or underflow occurred |
| clr_exc | input | 1 | Clear exception flags |
| init_cmd | input | 1 | Initialise the status word |
| restore_cmd | input | 1 | Load flags and condition bits from restore_word |
| restore_word | input | 16 | Saved status word |
| top_ptr | input | TOP_W | Stack top pointer supplied from outside |
| status_word | output | 16 | Assembled status word |
| exc_request | output | 1 | Unmasked exception pending |

## Verification
Several pairs of functions can act in the same cycle. A flag clear can coincide with a fresh exception report. An initialise or restore can coincide with both a compare and an exception. A mask change can arrive while a flag is already stored. The bench raises the command together with the competing operation in one cycle. It then reads the word one edge later and checks that the command's result alone shows in the flags, and that the condition bits show only what R4 or R5 allows. For the mask case, it changes the mask with no clock edge and checks that the summary, busy bit and request follow at once.

// File: rtl/fpsw_pkg.sv
package fpsw_pkg;

   localparam int WORD_W   = 16;
   localparam int FLAG_MAX = 6;
   localparam int POS_RSVD = 6;
   localparam int POS_SUM  = 7;
   localparam int POS_C0   = 8;
   localparam int POS_C1   = 9;
   localparam int POS_C2   = 10;
   localparam int POS_TOP  = 11;
   localparam int POS_C3   = 14;
   localparam int POS_BUSY = 15;

   typedef enum logic [2:0] {
      OPC_NONE    = 3'd0,
      OPC_CMP     = 3'd1,
      OPC_CMP_INT = 3'd2,
      OPC_REM     = 3'd3,
      OPC_TRIG    = 3'd4,
      OPC_ARITH   = 3'd5,
      OPC_LOAD    = 3'd6,
      OPC_RSVD    = 3'd7
   } opc_e;

   typedef struct packed {
      logic c3;
      logic c2;
      logic c1;
      logic c0;
   } cc_t;

endpackage

// File: rtl/fpsw_flag_bank.sv
module fpsw_flag_bank #(
   parameter int EXC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_cmd,
   input  logic             restore_cmd,
   input  logic             clr_exc,
   input  logic [EXC_W-1:0] restore_flags,
   input  logic [EXC_W-1:0] exc_in,
   output logic [EXC_W-1:0] flags_q
);

   // One sticky cell per exception; command priority: init, restore, clear, set.
   for (genvar i = 0; i < EXC_W; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (!rst_n || init_cmd) begin
            flags_q[i] <= 1'b0;
         end else if (restore_cmd) begin
            flags_q[i] <= restore_flags[i];
         end else if (clr_exc) begin
            flags_q[i] <= 1'b0;
         end else if (exc_in[i]) begin
            flags_q[i] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/fpsw_cc_unit.sv
module fpsw_cc_unit
   import fpsw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       init_cmd,
   input  logic       restore_cmd,
   input  cc_t        restore_cc,
   input  opc_e       op_class,
   input  logic [2:0] cmp_code,
   input  logic [2:0] quot_bits,
   input  logic       reduce_partial,
   input  logic       src_out_of_range,
   input  logic       round_up,
   input  logic       stack_fault,
   output cc_t        cc_q
);

   cc_t cc_d;

   always_comb begin
      cc_d = cc_q;
      unique case (op_class)
         OPC_CMP: begin
            cc_d.c3 = cmp_code[2];
            cc_d.c2 = cmp_code[1];
            cc_d.c0 = cmp_code[0];
            cc_d.c1 = stack_fault;
         end
         OPC_CMP_INT: begin
            cc_d.c1 = stack_fault;
         end
         OPC_REM: begin
            cc_d.c2 = reduce_partial;
            if (!reduce_partial) begin
               cc_d.c0 = quot_bits[2];
               cc_d.c3 = quot_bits[1];
               cc_d.c1 = quot_bits[0];
            end
         end
         OPC_TRIG: begin
            cc_d.c2 = src_out_of_range;
            if (!src_out_of_range) begin
               cc_d.c1 = round_up | stack_fault;
            end
         end
         OPC_ARITH: begin
            cc_d.c1 = round_up | stack_fault;
         end
         OPC_LOAD: begin
            cc_d.c1 = stack_fault;
         end
         default: begin
            cc_d = cc_q;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || init_cmd) begin
         cc_q <= '0;
      end else if (restore_cmd) begin
         cc_q <= restore_cc;
      end else begin
         cc_q <= cc_d;
      end
   end

endmodule

// File: rtl/fpu_status_word.sv
module fpu_status_word
   import fpsw_pkg::*;
#(
   parameter int EXC_W = 6,
   parameter int TOP_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EXC_W-1:0]  exc_in,
   input  logic [EXC_W-1:0]  exc_mask,
   input  logic [2:0]        op_class,
   input  logic [2:0]        cmp_code,
   input  logic [2:0]        quot_bits,
   input  logic              reduce_partial,
   input  logic              src_out_of_range,
   input  logic              round_up,
   input  logic              stack_fault,
   input  logic              clr_exc,
   input  logic              init_cmd,
   input  logic              restore_cmd,
   input  logic [WORD_W-1:0] restore_word,
   input  logic [TOP_W-1:0]  top_ptr,
   output logic [WORD_W-1:0] status_word,
   output logic              exc_request
);

   localparam int TOP_HI = POS_TOP + TOP_W - 1;

   if (EXC_W < 1 || EXC_W > FLAG_MAX) begin : g_bad_exc_w
      $error("EXC_W must lie in 1..%0d", FLAG_MAX);
   end
   if (TOP_HI >= POS_C3) begin : g_bad_top_w
      $error("TOP_W overlaps condition bit field");
   end

   logic [EXC_W-1:0] flags_q;
   cc_t              cc_q;
   cc_t              restore_cc;
   logic             summary;

   assign restore_cc = '{c3: restore_word[POS_C3], c2: restore_word[POS_C2],
                         c1: restore_word[POS_C1], c0: restore_word[POS_C0]};

   fpsw_flag_bank #(.EXC_W(EXC_W)) u_flags (
      .clk           (clk),
      .rst_n         (rst_n),
      .init_cmd      (init_cmd),
      .restore_cmd   (restore_cmd),
      .clr_exc       (clr_exc),
      .restore_flags (restore_word[EXC_W-1:0]),
      .exc_in        (exc_in),
      .flags_q       (flags_q)
   );

   fpsw_cc_unit u_cc (
      .clk              (clk),
      .rst_n            (rst_n),
      .init_cmd         (init_cmd),
      .restore_cmd      (restore_cmd),
      .restore_cc       (restore_cc),
      .op_class         (opc_e'(op_class)),
      .cmp_code         (cmp_code),
      .quot_bits        (quot_bits),
      .reduce_partial   (reduce_partial),
      .src_out_of_range (src_out_of_range),
      .round_up         (round_up),
      .stack_fault      (stack_fault),
      .cc_q             (cc_q)
   );

   // Summary follows the live mask, so unmasking a stored flag raises it at once.
   assign summary = |(flags_q & ~exc_mask);

   always_comb begin
      status_word                  = '0;
      status_word[EXC_W-1:0]       = flags_q;
      status_word[POS_RSVD]        = 1'b0;
      status_word[POS_SUM]         = summary;
      status_word[POS_C0]          = cc_q.c0;
      status_word[POS_C1]          = cc_q.c1;
      status_word[POS_C2]          = cc_q.c2;
      status_word[TOP_HI:POS_TOP]  = top_ptr;
      status_word[POS_C3]          = cc_q.c3;
      status_word[POS_BUSY]        = summary;
   end

   assign exc_request = summary;

endmodule

// File: rtl/fpu_status_word_chk.sv
module fpu_status_word_chk #(
   parameter int EXC_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic [EXC_W-1:0] exc_mask,
   input logic [2:0]       op_class,
   input logic [2:0]       cmp_code,
   input logic             stack_fault,
   input logic             clr_exc,
   input logic             init_cmd,
   input logic             restore_cmd,
   input logic [15:0]      status_word,
   input logic             exc_request
);

   logic no_cmd;
   assign no_cmd = !init_cmd && !restore_cmd;

   // R3: busy bit mirrors summary
   a_r3_busy_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      status_word[15] == status_word[7]);

   // R3: request output follows summary
   a_r3_request: assert property (@(posedge clk) disable iff (!rst_n)
      exc_request == status_word[7]);

   // R2: stored flags never drop without a command
   a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (no_cmd && !clr_exc) |=>
      ((status_word[EXC_W-1:0] & $past(status_word[EXC_W-1:0])) == $past(status_word[EXC_W-1:0])));

   // R4: clear wins over a simultaneous report
   a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_exc && no_cmd) |=> (status_word[EXC_W-1:0] == '0));

   // R5: initialise empties flags and condition bits
   a_r5_init: assert property (@(posedge clk) disable iff (!rst_n)
      init_cmd |=> ({status_word[14], status_word[10:8], status_word[EXC_W-1:0]} == '0));

   // R6: compare result lands in C3/C2/C0, stack fault in C1
   a_r6_compare: assert property (@(posedge clk) disable iff (!rst_n)
      (op_class == 3'd1 && no_cmd) |=>
      ({status_word[14], status_word[10], status_word[8]} == $past(cmp_code)
       && status_word[9] == $past(stack_fault)));

   // R11: idle classes keep condition bits
   a_r11_idle_cc: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_class == 3'd0 || op_class == 3'd7) && no_cmd) |=>
      $stable({status_word[14], status_word[10:8]}));

   // R12: reserved bit reads zero
   a_r12_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      status_word[6] == 1'b0);

   // R3: no summary when every flag is masked
   a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_word[EXC_W-1:0] & ~exc_mask) == '0) |-> !status_word[7]);

endmodule

bind fpu_status_word fpu_status_word_chk #(.EXC_W(EXC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .exc_mask    (exc_mask),
   .op_class    (op_class),
   .cmp_code    (cmp_code),
   .stack_fault (stack_fault),
   .clr_exc     (clr_exc),
   .init_cmd    (init_cmd),
   .restore_cmd (restore_cmd),
   .status_word (status_word),
   .exc_request (exc_request)
);

// File: tb/test_fpu_status_word.sv
module test_fpu_status_word;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 11;

   // {class, exc, mask, cmp, quot, partial, oor, round_up, sfault, clr, expected word}
   localparam logic [41:0] VEC [NV] = '{
      {3'd5, 6'b000001, 6'b000000, 3'b000, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hAA81},
      {3'd1, 6'b000000, 6'b000000, 3'b100, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hE881},
      {3'd6, 6'b100000, 6'b111111, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h6A21},
      {3'd3, 6'b000000, 6'b111110, 3'b000, 3'b101, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hABA1},
      {3'd3, 6'b000000, 6'b111111, 3'b000, 3'b010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2F21},
      {3'd4, 6'b000000, 6'b111111, 3'b000, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h2F21},
      {3'd4, 6'b000000, 6'b111111, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2921},
      {3'd2, 6'b000000, 6'b111111, 3'b111, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h2B21},
      {3'd1, 6'b000000, 6'b111111, 3'b111, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h6D21},
      {3'd0, 6'b000100, 6'b000000, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hEDA5},
      {3'd5, 6'b000010, 6'b000000, 3'b000, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h6F00}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic [5:0]  exc_in, exc_mask;
   logic [2:0]  op_class, cmp_code, quot_bits, top_ptr;
   logic        reduce_partial, src_out_of_range, round_up, stack_fault;
   logic        clr_exc, init_cmd, restore_cmd;
   logic [15:0] restore_word, status_word;
   logic        exc_request;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string tags [NV];

   always #(CLK_PERIOD/2) clk = ~clk;

   fpu_status_word i_fpu_status_word (
      .clk(clk), .rst_n(rst_n), .exc_in(exc_in), .exc_mask(exc_mask),
      .op_class(op_class), .cmp_code(cmp_code), .quot_bits(quot_bits),
      .reduce_partial(reduce_partial), .src_out_of_range(src_out_of_range),
      .round_up(round_up), .stack_fault(stack_fault), .clr_exc(clr_exc),
      .init_cmd(init_cmd), .restore_cmd(restore_cmd), .restore_word(restore_word),
      .top_ptr(top_ptr), .status_word(status_word), .exc_request(exc_request)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle();
      exc_in = '0; op_class = 3'd0; cmp_code = '0; quot_bits = '0;
      reduce_partial = 0; src_out_of_range = 0; round_up = 0; stack_fault = 0;
      clr_exc = 0; init_cmd = 0; restore_cmd = 0; restore_word = '0;
   endtask

   initial begin
      tags[0] = "R2_R10_arith"; tags[1] = "R6_equal";     tags[2] = "R3_R10_load_masked";
      tags[3] = "R8_rem_done";  tags[4] = "R8_rem_partial"; tags[5] = "R9_trig_oor";
      tags[6] = "R9_trig_in";   tags[7] = "R7_cmp_int";   tags[8] = "R6_unordered";
      tags[9] = "R11_none_exc"; tags[10] = "R4_clear_wins";

      rst_n = 1'b0; exc_mask = '0; top_ptr = 3'b101; idle();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      check("R1_reset_word", status_word, 16'h2800);
      check("R1_reset_req", {15'd0, exc_request}, 16'd0);

      for (int k = 0; k < NV; k++) begin
         op_class = VEC[k][41:39]; exc_in = VEC[k][38:33]; exc_mask = VEC[k][32:27];
         cmp_code = VEC[k][26:24]; quot_bits = VEC[k][23:21];
         reduce_partial = VEC[k][20]; src_out_of_range = VEC[k][19];
         round_up = VEC[k][18]; stack_fault = VEC[k][17]; clr_exc = VEC[k][16];
         @(negedge clk);
         check(tags[k], status_word, VEC[k][15:0]);
      end
      idle();

      // R3: masked exception, then unmask with no clock edge
      exc_in = 6'b000010; exc_mask = 6'b000010;
      @(negedge clk);
      idle();
      check("R3_masked_no_sum", status_word, 16'h6F02);
      exc_mask = 6'b000000; #1;
      check("R3_unmask_live", status_word, 16'hEF82);
      check("R3_request", {15'd0, exc_request}, 16'd1);
      // R12: top field follows input directly
      top_ptr = 3'b010; #1;
      check("R12_top_live", status_word, 16'hD782);
      top_ptr = 3'b101;

      // R5: initialise beats exception and compare in same cycle
      @(negedge clk);
      init_cmd = 1; exc_in = 6'b111111; op_class = 3'd1; cmp_code = 3'b111;
      @(negedge clk);
      idle();
      check("R5_init_wins", status_word, 16'h2800);

      // R5: restore beats clear, exception and compare; bits 15,7,6 ignored
      exc_mask = 6'b111111;
      restore_cmd = 1; restore_word = 16'hC5E3; clr_exc = 1; exc_in = 6'b000100;
      op_class = 3'd1; cmp_code = 3'b000; stack_fault = 1;
      @(negedge clk);
      idle();
      check("R5_restore", status_word, 16'h6D23);
      exc_mask = 6'b000000; #1;
      check("R5_restore_unmasked", status_word, 16'hEDA3);

      // R4: clear alone keeps condition bits
      clr_exc = 1;
      @(negedge clk);
      idle();
      check("R4_clear_keeps_cc", status_word, 16'h6D00);

      // R11: reserved class changes no condition bit
      op_class = 3'd7; cmp_code = 3'b000; stack_fault = 1;
      @(negedge clk);
      idle();
      check("R11_reserved_class", status_word, 16'h6D00);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule